// File: doc/BRIEF.md
# Byte-Framed Event Serializer

This block accepts one event word, made of 64 hit flags and a 24-bit timestamp, through a valid/ready input and sends it out on a single serial line. The line runs at one bit per tick. A tick lasts a programmable number of clock cycles, and the default of ten cycles gives 100 ns per bit at a 100 MHz clock. Each event goes out as eleven bytes. The eight hit bytes come first and the three timestamp bytes follow. Every byte is wrapped in a start bit, an odd-parity bit and a stop bit, so a byte takes 11 bit times and an event takes 121 bit times, which is 12.1 µs at the default rate.

The upstream buffer presents an event with `in_valid` and must hold `in_data` steady until a clock edge where `in_ready` is also high. The block takes the event at that edge. `in_ready` is high whenever the block is idle. During a frame it is high only in the final clock cycle of the last stop bit. This is how back-pressure reaches the buffer: a source that keeps `in_valid` high gets its next event sent straight after the stop bit, with no idle time. The `busy` flag is high while a frame is on the line. The line rests at 1 between frames.

Top module: `ser_event_tx`

## Requirements
- R1: After reset and whenever no frame is in flight, `ser_out` is 1, `busy` is 0 and `in_ready` is 1.
- R2: Each line bit is held for exactly TICK_DIV clock cycles (default 10). The start bit of a new frame appears in the first cycle after the accepting edge.
- R3: A frame is 11 bytes of 11 bits each, 121 bits in all. Each byte is sent as a 0 start bit, then its 8 data bits least significant first, then a parity bit, then a 1 stop bit.
- R4: The hit bytes are sent first, taking `in_data[7:0]` as byte 1 through `in_data[63:56]` as byte 8.
- R5: The timestamp bytes are sent next, most significant first: `in_data[87:80]`, then `in_data[79:72]`, then `in_data[71:64]`.
- R6: The parity bit gives odd parity: the 8 data bits and the parity bit together hold an odd number of ones.
- R7: While a frame is in flight, `busy` is 1 and `in_ready` is 0, except in the last cycle of the final stop bit. Changes on `in_data` or `in_valid` during the frame do not affect the bits on the line.
- R8: If `in_valid` is high at the end of a frame, the next frame's start bit follows the final stop bit directly. There is no idle bit between the frames and `busy` stays high.
- R9: In the cycle after the final stop bit of a frame that has no successor, `busy` returns to 0 and the line returns to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An event is offered on `in_data` |
| in_ready | output | 1 | The block takes the offered event at this edge |
| in_data | input | HIT_W+TS_W | Hit flags in bits 63:0, timestamp in bits 87:64 |
| ser_out | output | 1 | Serial line, idles at 1 |
| busy | output | 1 | A frame is in flight |

## Verification
Let the accepting edge be edge 0. Bit n of a frame then occupies the clock cycles between edges 10n and 10n+10. The bench therefore samples bit n at the falling edge four cycles into that window, and it checks at every other falling edge that the line has not moved within a bit. Start-bit presence is checked at the first falling edge after acceptance. The return to idle is checked at the falling edge right after edge 1210. For back-to-back frames, the bench reads the line continuously for 242 bit windows without re-aligning, so a single idle bit would shift every later sample and be caught.

// File: rtl/ser_pkg.sv
package ser_pkg;
  localparam int BYTE_W     = 8;
  localparam int FRAME_BITS = BYTE_W + 3;
  localparam int POS_W      = $clog2(FRAME_BITS);
  localparam int POS_START  = 0;
  localparam int POS_PAR    = BYTE_W + 1;
  localparam int POS_STOP   = BYTE_W + 2;

  // odd parity: the returned bit makes the total count of ones odd
  function automatic logic odd_par(input logic [BYTE_W-1:0] b);
    return ~^b;
  endfunction
endpackage

// File: rtl/ser_tick_div.sv
module ser_tick_div #(
  parameter int DIV = 10,
  parameter int CW  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          run,
  output logic [CW-1:0] cnt,
  output logic          bit_end
);
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  assign bit_end = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt <= '0;
    else if (restart) cnt <= '0;
    else if (run)     cnt <= bit_end ? '0 : cnt + 1'b1;
    else              cnt <= '0;
  end
endmodule

// File: rtl/ser_byte_pick.sv
module ser_byte_pick #(
  parameter int HIT_W = 64,
  parameter int TS_W  = 24,
  parameter int NB    = 11,
  parameter int BIW   = 4
) (
  input  logic [HIT_W+TS_W-1:0]      ev,
  input  logic [BIW-1:0]             idx,
  output logic [ser_pkg::BYTE_W-1:0] sel
);
  import ser_pkg::*;
  localparam int NH = HIT_W / BYTE_W;
  localparam int NT = TS_W / BYTE_W;

  logic [BYTE_W-1:0] lanes [NB];

  // hit bytes: lowest channel byte first
  for (genvar g = 0; g < NH; g++) begin : g_hit
    assign lanes[g] = ev[g*BYTE_W +: BYTE_W];
  end
  // timestamp bytes: most significant byte first
  for (genvar g = 0; g < NT; g++) begin : g_ts
    assign lanes[NH+g] = ev[HIT_W + (NT-1-g)*BYTE_W +: BYTE_W];
  end

  always_comb begin
    sel = '0;
    for (int i = 0; i < NB; i++)
      if (idx == BIW'(i)) sel = lanes[i];
  end
endmodule

// File: rtl/ser_frame_bits.sv
module ser_frame_bits (
  input  logic [ser_pkg::BYTE_W-1:0] data_byte,
  input  logic [ser_pkg::POS_W-1:0]  pos,
  output logic                       line_bit
);
  import ser_pkg::*;
  localparam int DW = $clog2(BYTE_W);

  always_comb begin
    if (pos == POS_W'(POS_START))
      line_bit = 1'b0;
    else if (pos < POS_W'(POS_PAR))
      line_bit = data_byte[DW'(pos - 1'b1)];
    else if (pos == POS_W'(POS_PAR))
      line_bit = odd_par(data_byte);
    else
      line_bit = 1'b1;
  end
endmodule

// File: rtl/ser_event_tx.sv
module ser_event_tx #(
  parameter int HIT_W    = 64,
  parameter int TS_W     = 24,
  parameter int TICK_DIV = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [HIT_W+TS_W-1:0] in_data,
  output logic                  ser_out,
  output logic                  busy
);
  import ser_pkg::*;
  localparam int EV_W = HIT_W + TS_W;
  localparam int NB   = (HIT_W / BYTE_W) + (TS_W / BYTE_W);
  localparam int BIW  = $clog2(NB);
  localparam int CW   = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic [EV_W-1:0]   ev_q;
  logic [BIW-1:0]    byte_idx;
  logic [POS_W-1:0]  bit_idx;
  logic [CW-1:0]     tick_cnt;
  logic              bit_end;
  logic [BYTE_W-1:0] cur_byte;
  logic              frame_bit;
  logic              last_pos, last_byte, frame_done, accept;

  assign last_pos   = (bit_idx == POS_W'(POS_STOP));
  assign last_byte  = (byte_idx == BIW'(NB - 1));
  assign frame_done = busy && bit_end && last_pos && last_byte;
  assign in_ready   = !busy || frame_done;
  assign accept     = in_valid && in_ready;

  ser_tick_div #(.DIV(TICK_DIV), .CW(CW)) u_tick (
    .clk(clk), .rst_n(rst_n), .restart(accept), .run(busy),
    .cnt(tick_cnt), .bit_end(bit_end)
  );

  ser_byte_pick #(.HIT_W(HIT_W), .TS_W(TS_W), .NB(NB), .BIW(BIW)) u_pick (
    .ev(ev_q), .idx(byte_idx), .sel(cur_byte)
  );

  ser_frame_bits u_bits (
    .data_byte(cur_byte), .pos(bit_idx), .line_bit(frame_bit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      ev_q     <= '0;
      byte_idx <= '0;
      bit_idx  <= '0;
    end else if (accept) begin
      busy     <= 1'b1;
      ev_q     <= in_data;
      byte_idx <= '0;
      bit_idx  <= '0;
    end else if (busy && bit_end) begin
      if (last_pos) begin
        bit_idx <= '0;
        if (last_byte) busy <= 1'b0;
        else           byte_idx <= byte_idx + 1'b1;
      end else begin
        bit_idx <= bit_idx + 1'b1;
      end
    end
  end

  assign ser_out = busy ? frame_bit : 1'b1;
endmodule

// File: rtl/ser_event_tx_chk.sv
module ser_event_tx_chk #(
  parameter int EV_W = 88,
  parameter int CW   = 4,
  parameter int PW   = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic            busy,
  input logic            ser_out,
  input logic [PW-1:0]   bit_idx,
  input logic [CW-1:0]   tick_cnt,
  input logic [EV_W-1:0] ev_q
);
  localparam logic [PW-1:0] STOP = PW'(ser_pkg::POS_STOP);

  p_idle_line_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> ser_out);
  p_idle_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> in_ready);
  p_bit_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && tick_cnt != '0) |-> $stable(ser_out));
  p_start_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (busy && !ser_out && bit_idx == '0));
  p_start_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bit_idx == '0) |-> !ser_out);
  p_stop_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bit_idx == STOP) |-> ser_out);
  p_no_ready_midframe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bit_idx != STOP) |-> !in_ready);
  p_hold_event_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(in_valid && in_ready)) |=> $stable(ev_q));
  p_back_to_back_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && in_valid && in_ready) |=> busy);
endmodule

bind ser_event_tx ser_event_tx_chk #(.EV_W(EV_W), .CW(CW), .PW(ser_pkg::POS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .busy(busy), .ser_out(ser_out), .bit_idx(bit_idx), .tick_cnt(tick_cnt),
  .ev_q(ev_q)
);

// File: tb/ser_event_tx_tb.sv
module ser_event_tx_tb;
  localparam int TD = 10;
  localparam int FB = 121;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready, ser_out, busy;
  logic [87:0] in_data = '0;

  int checks = 0;
  int failures = 0;
  logic line_bits [0:2*FB-1];
  int stable_err, ready_err, start_err;

  always #5 clk = ~clk;

  ser_event_tx u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .ser_out(ser_out), .busy(busy)
  );

  // {timestamp, hits, expected first byte, expected last byte}
  localparam logic [103:0] VEC [5] = '{
    {24'h000000, 64'h0000_0000_0000_0000, 8'h00, 8'h00},
    {24'hFFFFFF, 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF, 8'hFF},
    {24'hA5C33C, 64'h0123_4567_89AB_CDEF, 8'hEF, 8'h3C},
    {24'h800001, 64'h8000_0000_0000_0001, 8'h01, 8'h01},
    {24'h13579B, 64'h00FF_5A3C_0F18_7E81, 8'h81, 8'h9B}
  };

  task automatic chk(input bit ok, input string req, input logic [87:0] act,
                     input logic [87:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic offer(input logic [87:0] ev);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = ev;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic collect(input int nbits, input bit b2b, input logic [87:0] nxt);
    bit acc_pending = 1'b0;
    logic prev = 1'b1;
    stable_err = 0; ready_err = 0; start_err = 0;
    for (int c = 0; c < nbits*TD; c++) begin
      @(negedge clk);
      if (c == 0) begin
        if (b2b) in_data = nxt;
        else     in_valid = 1'b0;
      end else if (acc_pending) begin
        in_valid = 1'b0;
      end
      if (!b2b && c == 300) begin in_valid = 1'b1; in_data = ~in_data; end
      if (!b2b && c == 301) in_valid = 1'b0;
      acc_pending = in_valid && in_ready;
      if (c == 0 && (!busy || ser_out)) start_err++;
      if (c % TD == 4) line_bits[c/TD] = ser_out;
      if (c % TD != 0 && ser_out != prev) stable_err++;
      prev = ser_out;
      if (!busy || (in_ready && (c % (FB*TD)) != FB*TD-1)) ready_err++;
    end
  endtask

  task automatic check_frame(input int base, input logic [87:0] ev,
                             input logic [7:0] ef, input logic [7:0] el,
                             input bit use_tbl);
    logic [7:0]  rb [11];
    logic [10:0] starts, stops, pars, exp_pars;
    logic [63:0] rx_hit;
    logic [23:0] rx_ts;
    logic [7:0]  eb;
    for (int b = 0; b < 11; b++) begin
      for (int k = 0; k < 8; k++) rb[b][k] = line_bits[base + 11*b + 1 + k];
      starts[b] = line_bits[base + 11*b];
      pars[b]   = line_bits[base + 11*b + 9];
      stops[b]  = line_bits[base + 11*b + 10];
      eb = (b < 8) ? ev[8*b +: 8] : ev[64 + 8*(10-b) +: 8];
      exp_pars[b] = ~(^eb);
    end
    for (int b = 0; b < 8; b++) rx_hit[8*b +: 8] = rb[b];
    rx_ts = {rb[8], rb[9], rb[10]};
    chk(rx_hit == ev[63:0], "R4 hit bytes", 88'(rx_hit), 88'(ev[63:0]));
    chk(rx_ts == ev[87:64], "R5 timestamp bytes", 88'(rx_ts), 88'(ev[87:64]));
    chk(starts == 11'h000 && stops == 11'h7FF, "R3 start/stop framing",
        88'({starts, stops}), 88'({11'h000, 11'h7FF}));
    chk(pars == exp_pars, "R6 odd parity", 88'(pars), 88'(exp_pars));
    if (use_tbl) begin
      chk(rb[0] == ef, "R4 first byte", 88'(rb[0]), 88'(ef));
      chk(rb[10] == el, "R5 last byte", 88'(rb[10]), 88'(el));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1: state during and after reset
    repeat (3) @(negedge clk);
    chk(ser_out && !busy && in_ready, "R1 in reset",
        88'({ser_out, busy, in_ready}), 88'(3'b101));
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(ser_out && !busy && in_ready, "R1 after reset",
        88'({ser_out, busy, in_ready}), 88'(3'b101));

    // table of single events, each with a mid-frame disturbance on the input
    for (int i = 0; i < 5; i++) begin
      offer(VEC[i][103:16]);
      collect(FB, 1'b0, '0);
      chk(start_err == 0, "R2 start bit after accept", 88'(start_err), 88'(0));
      chk(stable_err == 0, "R2 bit held TICK_DIV cycles", 88'(stable_err), 88'(0));
      chk(ready_err == 0, "R7 busy/ready in frame", 88'(ready_err), 88'(0));
      check_frame(0, VEC[i][103:16], VEC[i][15:8], VEC[i][7:0], 1'b1);
      @(negedge clk);
      chk(!busy && ser_out && in_ready, "R9 idle after frame",
          88'({busy, ser_out, in_ready}), 88'(3'b011));
      repeat (7) @(negedge clk);
      chk(ser_out && !busy, "R1 line idles high", 88'({ser_out, busy}), 88'(2'b10));
    end

    // R8: two frames back to back with in_valid held high
    offer({24'hC0FFEE, 64'hDEAD_BEEF_0BAD_F00D});
    collect(2*FB, 1'b1, {24'h010203, 64'hFEDC_BA98_7654_3210});
    chk(stable_err == 0, "R8 no gap / bit timing", 88'(stable_err), 88'(0));
    chk(ready_err == 0, "R8 busy held across frames", 88'(ready_err), 88'(0));
    check_frame(0, {24'hC0FFEE, 64'hDEAD_BEEF_0BAD_F00D}, 8'h0, 8'h0, 1'b0);
    check_frame(FB, {24'h010203, 64'hFEDC_BA98_7654_3210}, 8'h0, 8'h0, 1'b0);
    @(negedge clk);
    chk(!busy && ser_out, "R9 idle after second frame",
        88'({busy, ser_out}), 88'(2'b01));

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule